// File: doc/BRIEF.md
# Microframe Index and Periodic-Enable Sequencer

This block holds the 14-bit frame index of a USB 2.0 host controller. It also holds the frame number that goes out in start-of-frame packets. The low three bits of the index count the eight microframes of a frame, and the upper eleven bits count frames. The frame index moves forward by one on each microframe tick while the controller is running. The start-of-frame number follows it one microframe late: it takes up a new frame number only when the microframe field steps from 0 to 1.

Software can overwrite the index at any time. Software also sets a periodic-schedule enable bit. The block samples that bit only while the microframe field is zero, so an enable or disable takes effect at a frame boundary and never part-way through a frame. The sampled value is reported as a status bit. The block also drives the frame-list fetch: a one-cycle strobe and an entry address, issued at each natural frame rollover while the schedule is on.

Top module: `uframe_seq`

## Requirements
- R1: While rst is high, all of the following are zero on the next clock edge: frame_idx, sof_val, psched_on, list_fetch and list_addr.
- R2: A cycle with run=1, tick=1 and sw_wr=0 adds one to frame_idx on the next edge. The index wraps from 16383 to 0.
- R3: When run=0 and sw_wr=0, frame_idx keeps its value, even when tick pulses.
- R4: Bits [2:0] of frame_idx are the microframe field. An advance from field value 7 gives field value 0 and adds one to the frame field, bits [13:3].
- R5: sof_val (11 bits) takes the value of frame_idx[13:3] on an advance that moves the microframe field from 0 to 1. It changes at no other advance. Through microframe 0 it therefore still shows the previous frame number.
- R6: When sw_wr=1, frame_idx is loaded with sw_wdata and sof_val with sw_wdata[13:3] on the next edge. This holds whatever tick and run are doing.
- R7: On every edge where frame_idx[2:0] was 0, psched_on takes the value of sw_pen. On any other edge psched_on holds, so a change to sw_pen in microframes 1 to 7 has no effect.
- R8: list_fetch pulses for exactly one cycle, two edges after an advance that wraps the microframe field from 7 to 0, and only if sw_pen was 1 on the second of those edges. On that same edge list_addr becomes list_base + 4*frame_idx[12:3]. A software write that sets the field to 0 does not start a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Microframe tick, one cycle per 125 us |
| run | input | 1 | Run control; the index advances only while this is high |
| sw_wr | input | 1 | Software write strobe for the frame index |
| sw_wdata | input | 14 | Frame index value to write |
| sw_pen | input | 1 | Software periodic-schedule enable |
| list_base | input | 32 | Base address of the periodic frame list |
| frame_idx | output | 14 | Current frame index |
| sof_val | output | 11 | Frame number for start-of-frame packets |
| psched_on | output | 1 | Periodic-schedule status (sampled enable) |
| list_fetch | output | 1 | One-cycle frame-list fetch strobe |
| list_addr | output | 32 | Frame-list entry address for the fetch |

## Verification
frame_idx and sof_val change one edge after the tick or write that causes the change. psched_on changes one edge after a cycle in which the microframe field is zero. list_fetch and list_addr appear two edges after the 7-to-0 wrap, because an internal frame-start flag adds one stage. The bench drives inputs at the falling edge and steps a reference model at the rising edge, using the pre-edge state and inputs. It compares every output at the next falling edge, so each result is sampled in the cycle it is due. Directed sequences cover the microframe-0 lag of sof_val, the full index wrap, a write colliding with a tick, ticks while run is low, and an enable change made mid-frame.

// File: rtl/uframe_pkg.sv
package uframe_pkg;

    localparam int unsigned IDX_W_DEF   = 14;
    localparam int unsigned UF_W_DEF    = 3;
    localparam int unsigned LIST_W_DEF  = 10;
    localparam int unsigned ADDR_W_DEF  = 32;
    localparam int unsigned ESHIFT_DEF  = 2;

    // Events decoded from the index counter, consumed by the neighbours.
    typedef struct packed {
        logic sof_step;   // advance out of microframe 0
        logic wrap;       // advance from last microframe into microframe 0
        logic uf0;        // microframe field currently zero
    } uf_evt_t;

    function automatic logic all_ones(input logic [7:0] v, input int unsigned w);
        logic r;
        r = 1'b1;
        for (int i = 0; i < 8; i++)
            if (i < int'(w)) r = r & v[i];
        return r;
    endfunction

endpackage

// File: rtl/uframe_counter.sv
module uframe_counter
    import uframe_pkg::*;
#(
    parameter int unsigned IDX_W = IDX_W_DEF,
    parameter int unsigned UF_W  = UF_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             sw_wr,
    input  logic [IDX_W-1:0] sw_wdata,
    output logic [IDX_W-1:0] idx,
    output uf_evt_t          evt
);
    localparam logic [UF_W-1:0] UF_LAST = {UF_W{1'b1}};

    logic adv;

    assign adv          = run & tick & ~sw_wr;
    assign evt.uf0      = (idx[UF_W-1:0] == '0);
    assign evt.sof_step = adv & evt.uf0;
    assign evt.wrap     = adv & (idx[UF_W-1:0] == UF_LAST);

    always_ff @(posedge clk) begin
        if (rst)
            idx <= '0;
        else if (sw_wr)
            idx <= sw_wdata;
        else if (adv)
            idx <= idx + 1'b1;
    end

endmodule

// File: rtl/sof_tracker.sv
module sof_tracker #(
    parameter int unsigned FR_W = 11
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sw_wr,
    input  logic [FR_W-1:0] wr_frame,
    input  logic            sof_step,
    input  logic [FR_W-1:0] cur_frame,
    output logic [FR_W-1:0] sof
);
    always_ff @(posedge clk) begin
        if (rst)
            sof <= '0;
        else if (sw_wr)
            sof <= wr_frame;
        else if (sof_step)
            sof <= cur_frame;
    end
endmodule

// File: rtl/psched_sync.sv
module psched_sync #(
    parameter int unsigned LIST_W = 10,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned ESHIFT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_pen,
    input  logic              uf0,
    input  logic              wrap,
    input  logic [LIST_W-1:0] list_idx,
    input  logic [ADDR_W-1:0] list_base,
    output logic              psched_on,
    output logic              list_fetch,
    output logic [ADDR_W-1:0] list_addr
);
    localparam int unsigned PAD_W = ADDR_W - LIST_W - ESHIFT;

    logic              frame_start;
    logic [ADDR_W-1:0] offset;

    assign offset = {{PAD_W{1'b0}}, list_idx, {ESHIFT{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_start <= 1'b0;
            psched_on   <= 1'b0;
            list_fetch  <= 1'b0;
            list_addr   <= '0;
        end else begin
            frame_start <= wrap;
            if (uf0)
                psched_on <= sw_pen;
            list_fetch <= frame_start & sw_pen;
            if (frame_start)
                list_addr <= list_base + offset;
        end
    end
endmodule

// File: rtl/uframe_seq.sv
module uframe_seq
    import uframe_pkg::*;
#(
    parameter int unsigned IDX_W  = IDX_W_DEF,
    parameter int unsigned UF_W   = UF_W_DEF,
    parameter int unsigned LIST_W = LIST_W_DEF,
    parameter int unsigned ADDR_W = ADDR_W_DEF,
    parameter int unsigned ESHIFT = ESHIFT_DEF,
    localparam int unsigned FR_W  = IDX_W - UF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              run,
    input  logic              sw_wr,
    input  logic [IDX_W-1:0]  sw_wdata,
    input  logic              sw_pen,
    input  logic [ADDR_W-1:0] list_base,
    output logic [IDX_W-1:0]  frame_idx,
    output logic [FR_W-1:0]   sof_val,
    output logic              psched_on,
    output logic              list_fetch,
    output logic [ADDR_W-1:0] list_addr
);
    uf_evt_t evt;

    uframe_counter #(.IDX_W(IDX_W), .UF_W(UF_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .run      (run),
        .sw_wr    (sw_wr),
        .sw_wdata (sw_wdata),
        .idx      (frame_idx),
        .evt      (evt)
    );

    sof_tracker #(.FR_W(FR_W)) u_sof (
        .clk       (clk),
        .rst       (rst),
        .sw_wr     (sw_wr),
        .wr_frame  (sw_wdata[IDX_W-1:UF_W]),
        .sof_step  (evt.sof_step),
        .cur_frame (frame_idx[IDX_W-1:UF_W]),
        .sof       (sof_val)
    );

    psched_sync #(.LIST_W(LIST_W), .ADDR_W(ADDR_W), .ESHIFT(ESHIFT)) u_ps (
        .clk        (clk),
        .rst        (rst),
        .sw_pen     (sw_pen),
        .uf0        (evt.uf0),
        .wrap       (evt.wrap),
        .list_idx   (frame_idx[UF_W+LIST_W-1:UF_W]),
        .list_base  (list_base),
        .psched_on  (psched_on),
        .list_fetch (list_fetch),
        .list_addr  (list_addr)
    );
endmodule

// File: rtl/uframe_seq_chk.sv
module uframe_seq_chk #(
    parameter int unsigned IDX_W = 14,
    parameter int unsigned FR_W  = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             run,
    input logic             sw_wr,
    input logic [IDX_W-1:0] sw_wdata,
    input logic [IDX_W-1:0] frame_idx,
    input logic [FR_W-1:0]  sof_val,
    input logic             psched_on,
    input logic             list_fetch
);
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !sw_wr) |=> frame_idx == IDX_W'($past(frame_idx) + 1'b1));

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !sw_wr) |=> $stable(frame_idx));

    a_r6_write: assert property (@(posedge clk) disable iff (rst)
        sw_wr |=> (frame_idx == $past(sw_wdata)));

    a_r5_sof_still: assert property (@(posedge clk) disable iff (rst)
        (!sw_wr && !(run && tick && frame_idx[2:0] == 3'd0)) |=> $stable(sof_val));

    a_r7_mid_frame: assert property (@(posedge clk) disable iff (rst)
        (frame_idx[2:0] != 3'd0) |=> $stable(psched_on));

    a_r8_fetch_on: assert property (@(posedge clk) disable iff (rst)
        list_fetch |-> psched_on);

    a_r8_one_pulse: assert property (@(posedge clk) disable iff (rst)
        list_fetch |=> !list_fetch);
endmodule

bind uframe_seq uframe_seq_chk #(.IDX_W(IDX_W), .FR_W(FR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .run        (run),
    .sw_wr      (sw_wr),
    .sw_wdata   (sw_wdata),
    .frame_idx  (frame_idx),
    .sof_val    (sof_val),
    .psched_on  (psched_on),
    .list_fetch (list_fetch)
);

// File: tb/tb_uframe_seq.sv
`timescale 1ns/1ps
module tb_uframe_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0, run = 1'b0, sw_wr = 1'b0, sw_pen = 1'b0;
    logic [13:0] sw_wdata = '0;
    logic [31:0] list_base = 32'h0010_0000;
    logic [13:0] frame_idx;
    logic [10:0] sof_val;
    logic        psched_on, list_fetch;
    logic [31:0] list_addr;

    int errors = 0, checks = 0;
    bit done = 1'b0;

    // reference state
    logic [13:0] m_idx;
    logic [10:0] m_sof;
    logic        m_ps, m_nf, m_fetch;
    logic [31:0] m_addr;
    string       idx_tag, sof_tag;

    always #5 clk = ~clk;

    uframe_seq dut (
        .clk(clk), .rst(rst), .tick(tick), .run(run), .sw_wr(sw_wr),
        .sw_wdata(sw_wdata), .sw_pen(sw_pen), .list_base(list_base),
        .frame_idx(frame_idx), .sof_val(sof_val), .psched_on(psched_on),
        .list_fetch(list_fetch), .list_addr(list_addr)
    );

    function automatic logic [13:0] next_idx(logic [13:0] cur);
        if (sw_wr) return sw_wdata;
        if (run && tick) return cur + 14'd1;
        return cur;
    endfunction

    function automatic logic [10:0] next_sof(logic [10:0] cur, logic [13:0] idx);
        if (sw_wr) return sw_wdata[13:3];
        if (run && tick && idx[2:0] == 3'd0) return idx[13:3];
        return cur;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_edge();
        logic [13:0] o_idx;
        o_idx = m_idx;
        if (rst) begin
            m_idx = '0; m_sof = '0; m_ps = 0; m_nf = 0; m_fetch = 0; m_addr = '0;
            idx_tag = "R1"; sof_tag = "R1";
            return;
        end
        idx_tag = sw_wr ? "R6" : (run && tick) ? ((o_idx[2:0] == 3'd7) ? "R4" : "R2") : "R3";
        sof_tag = sw_wr ? "R6" : "R5";
        m_fetch = m_nf && sw_pen;
        if (m_nf) m_addr = list_base + {20'd0, o_idx[12:3], 2'b00};
        m_nf  = run && tick && !sw_wr && (o_idx[2:0] == 3'd7);
        if (o_idx[2:0] == 3'd0) m_ps = sw_pen;
        m_sof = next_sof(m_sof, o_idx);
        m_idx = next_idx(o_idx);
    endtask

    task automatic compare();
        check(frame_idx == m_idx, idx_tag, 32'(frame_idx), 32'(m_idx));
        check(sof_val == m_sof, sof_tag, 32'(sof_val), 32'(m_sof));
        check(psched_on == m_ps, "R7", 32'(psched_on), 32'(m_ps));
        check(list_fetch == m_fetch, "R8", 32'(list_fetch), 32'(m_fetch));
        check(list_addr == m_addr, "R8", list_addr, m_addr);
    endtask

    // one cycle: inputs already set at negedge; advance model; compare at next negedge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic drive(input logic t, input logic r, input logic w, input logic [13:0] wd, input logic p);
        tick = t; run = r; sw_wr = w; sw_wdata = wd; sw_pen = p;
        step();
    endtask

    initial begin
        m_idx = '0; m_sof = '0; m_ps = 0; m_nf = 0; m_fetch = 0; m_addr = '0;
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        rst = 1; step(); step();
        // R1 reset state
        check(frame_idx == 0 && sof_val == 0 && !psched_on && !list_fetch && list_addr == 0,
              "R1", 32'(frame_idx), 32'd0);
        rst = 0;

        // R6: load frame 0, microframe 6; R4/R5 lag across a frame boundary
        drive(0, 1, 1, 14'h0006, 1);
        drive(1, 1, 0, 0, 1);            // -> uf 7
        drive(1, 1, 0, 0, 1);            // -> frame 1 uf 0, sof stays 0
        check(sof_val == 11'd0 && frame_idx == 14'h0008, "R5", 32'(sof_val), 32'd0);
        drive(0, 1, 0, 0, 1);            // fetch due here
        check(list_fetch == 1'b1, "R8", 32'(list_fetch), 32'd1);
        drive(1, 1, 0, 0, 1);            // -> uf 1, sof = 1
        check(sof_val == 11'd1, "R5", 32'(sof_val), 32'd1);

        // R7: enable dropped mid-frame is ignored
        drive(1, 1, 0, 0, 0);
        drive(0, 1, 0, 0, 0);
        check(psched_on == 1'b1, "R7", 32'(psched_on), 32'd1);

        // R2 full wrap
        drive(0, 1, 1, 14'h3FFF, 0);
        drive(1, 1, 0, 0, 0);
        check(frame_idx == 14'd0, "R2", 32'(frame_idx), 32'd0);

        // R6 write beats tick
        drive(1, 1, 1, 14'h1235, 0);
        check(frame_idx == 14'h1235 && sof_val == 11'h246, "R6", 32'(frame_idx), 32'h1235);

        // R3 ticks ignored while stopped
        for (int i = 0; i < 5; i++) drive(1, 0, 0, 0, 1);
        check(frame_idx == 14'h1235, "R3", 32'(frame_idx), 32'h1235);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 199) == 0) list_base = $urandom & 32'hFFFF_F000;
            drive($urandom_range(0, 2) == 0,
                  $urandom_range(0, 9) != 0,
                  $urandom_range(0, 49) == 0,
                  14'($urandom),
                  ($urandom_range(0, 19) == 0) ? ~sw_pen : sw_pen);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule